// File: doc/BRIEF.md
# Breaker Failure Timing Logic

This block supervises breaker-failure protection from sampled digital flags. Upstream logic supplies a group of three-pole initiate requests, a group of single-pole initiate requests, and phase and neutral fault-detector pickup flags. When any initiate appears, the block opens a control window of programmable length. It retrips the local breaker for as long as that window runs. Each initiate group has its own delay timer. If an initiate of that group is still present when its delay has elapsed, and the group's supervising detector is picked up, the block sets a latched backup-breaker trip output for that group.

All timers count a one-millisecond tick enable, `tick_i`, that is sampled on the system clock. The delay and window lengths come from 16-bit setting inputs. The control window does two jobs. It latches the initiates, so the delay keeps running when an initiate drops briefly. It also closes the period in which a failure may be declared. After the window has expired and every initiate is low, the block returns to idle and clears its latched trips.

Top module: `bf_supervisor`

## Requirements
- R1: The control window starts at a clock edge when the block is idle, `win_lim_i` is nonzero and at least one initiate of either group is high. `retrip_o` is high from the next cycle on. The window counts `win_lim_i` ticks and then ends, and `retrip_o` falls at the edge that samples the last tick.
- R2: `trip3_o` sets at an edge when all of these hold: the window is running, at least `dly3_i` ticks have been counted on the three-pole path, a three-pole initiate is high at that edge, and the phase or the neutral pickup is high.
- R3: Once a group's initiate is seen while the window is starting or running, the block holds it for that group. From the following cycle, every tick inside the window advances that group's delay count, even after the initiate has dropped.
- R4: No trip output sets after the control window has ended, whatever the initiates and pickups do.
- R5: A trip output that has set stays high while the pickups or initiates drop. It falls only on the clear described in R9, or on reset.
- R6: `trip1_o` follows the same rule as R2 on the single-pole path. It uses the `dly1_i` delay and the single-pole initiates, and is supervised by the phase pickup alone.
- R7: A neutral pickup without a phase pickup never sets `trip1_o`.
- R8: A delay setting of zero disables that group's trip output. A window setting of zero keeps the whole block idle, so `retrip_o` and both trips stay low.
- R9: After the window has expired, the first edge that samples every initiate low clears both trips and returns the block to idle. Until that edge, a held initiate does not open a new window.
- R10: While `rst_ni` is low, all counts and latches are zero and all outputs are low, whatever the clock is doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-millisecond timing enable, high for one clock |
| init3_i | input | 3 | Three-pole initiate requests |
| init1_i | input | 2 | Single-pole initiate requests |
| ph_pu_i | input | 1 | Phase fault detector picked up |
| nt_pu_i | input | 1 | Neutral fault detector picked up |
| dly3_i | input | 16 | Three-pole delay, in ticks (0 disables the path) |
| dly1_i | input | 16 | Single-pole delay, in ticks (0 disables the path) |
| win_lim_i | input | 16 | Control window length, in ticks (0 disables the block) |
| trip3_o | output | 1 | Latched three-pole backup-breaker trip |
| trip1_o | output | 1 | Latched single-pole backup-breaker trip |
| retrip_o | output | 1 | Retrip of the local breaker while the window runs |

## Verification
The assertions assume that the settings do not change while a window is open and that `tick_i` is a single-cycle pulse. They also assume that initiates and pickups are synchronous to the clock and are sampled only at rising edges. The stimulus follows these rules. It changes every input on the falling edge, and it changes the delay and window settings only while the block is idle with all initiates low. It also generates the tick from a fixed divider of the clock. Pickups are switched on before, during and after the window, so that the window boundary and the latch-in behaviour are both exercised against the behavioural model.

// File: rtl/bf_pkg.sv
package bf_pkg;
  typedef enum logic [1:0] {
    WIN_IDLE = 2'd0,
    WIN_RUN  = 2'd1,
    WIN_DONE = 2'd2
  } win_state_e;
endpackage

// File: rtl/bf_window.sv
module bf_window #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          any_init_i,
  input  logic [TW-1:0] limit_i,
  output logic          start_o,
  output logic          run_o,
  output logic          clear_o
);
  import bf_pkg::*;

  win_state_e    state_q, state_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic [TW:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;
  assign start_o = (state_q == WIN_IDLE) && any_init_i && (limit_i != '0);
  assign run_o   = (state_q == WIN_RUN);
  // idle holds everything cleared; expiry clears once all initiates are gone
  assign clear_o = (state_q == WIN_IDLE) || ((state_q == WIN_DONE) && !any_init_i);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      WIN_IDLE: if (start_o) begin
        state_d = WIN_RUN;
        cnt_d   = '0;
      end
      WIN_RUN: if (tick_i) begin
        if (cnt_nxt >= {1'b0, limit_i}) state_d = WIN_DONE;
        else                            cnt_d   = cnt_nxt[TW-1:0];
      end
      WIN_DONE: if (!any_init_i) state_d = WIN_IDLE;
      default: state_d = WIN_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WIN_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/bf_delay.sv
module bf_delay #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          seed_i,
  input  logic          open_i,
  input  logic          run_i,
  input  logic          clear_i,
  input  logic [TW-1:0] limit_i,
  output logic          done_o
);
  logic          lat_q;
  logic [TW-1:0] cnt_q;

  assign done_o = (limit_i != '0) && (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lat_q <= (clear_i ? 1'b0 : lat_q) | (seed_i & open_i);
      if (clear_i)
        cnt_q <= '0;
      else if (run_i && lat_q && tick_i && (cnt_q < limit_i))
        cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bf_trip.sv
module bf_trip (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic clear_i,
  output logic trip_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      trip_o <= 1'b0;
    else if (clear_i) trip_o <= 1'b0;
    else if (arm_i)   trip_o <= 1'b1;
  end
endmodule

// File: rtl/bf_supervisor.sv
module bf_supervisor #(
  parameter int N3 = 3,
  parameter int N1 = 2,
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [N3-1:0] init3_i,
  input  logic [N1-1:0] init1_i,
  input  logic          ph_pu_i,
  input  logic          nt_pu_i,
  input  logic [TW-1:0] dly3_i,
  input  logic [TW-1:0] dly1_i,
  input  logic [TW-1:0] win_lim_i,
  output logic          trip3_o,
  output logic          trip1_o,
  output logic          retrip_o
);
  localparam int NP = 2;  // path 0: three-pole, path 1: single-pole

  logic          any3, any1, start, run, clear;
  logic [NP-1:0] seed, sup, done, trip;
  logic [TW-1:0] lim [NP];

  assign any3 = |init3_i;
  assign any1 = |init1_i;
  assign seed = {any1, any3};
  assign sup  = {ph_pu_i, ph_pu_i | nt_pu_i};
  assign lim[0] = dly3_i;
  assign lim[1] = dly1_i;

  bf_window #(.TW(TW)) u_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .any_init_i (any3 | any1),
    .limit_i    (win_lim_i),
    .start_o    (start),
    .run_o      (run),
    .clear_o    (clear)
  );

  for (genvar g = 0; g < NP; g++) begin : g_path
    bf_delay #(.TW(TW)) u_dly (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .seed_i  (seed[g]),
      .open_i  (start | run),
      .run_i   (run),
      .clear_i (clear),
      .limit_i (lim[g]),
      .done_o  (done[g])
    );
    bf_trip u_trip (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .arm_i   (run & done[g] & seed[g] & sup[g]),
      .clear_i (clear),
      .trip_o  (trip[g])
    );
  end

  assign trip3_o  = trip[0];
  assign trip1_o  = trip[1];
  assign retrip_o = run;
endmodule

// File: rtl/bf_supervisor_chk.sv
module bf_supervisor_chk #(
  parameter int N3 = 3,
  parameter int N1 = 2,
  parameter int TW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [N3-1:0] init3_i,
  input logic [N1-1:0] init1_i,
  input logic          ph_pu_i,
  input logic          nt_pu_i,
  input logic [TW-1:0] dly3_i,
  input logic          trip3_o,
  input logic          trip1_o,
  input logic          retrip_o
);
  AST_RETRIP_NEEDS_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(retrip_o) |-> $past(|{init3_i, init1_i})); // R1
  AST_TRIP3_SUPERVISED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trip3_o) |-> $past(|init3_i) && $past(ph_pu_i | nt_pu_i)); // R2
  AST_TRIP3_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trip3_o) |-> $past(retrip_o)); // R4
  AST_TRIP1_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trip1_o) |-> $past(retrip_o)); // R4
  AST_TRIP3_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(trip3_o) |-> $past(~|{init3_i, init1_i}) && !$past(retrip_o)); // R5
  AST_TRIP1_PHASE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trip1_o) |-> $past(ph_pu_i) && $past(|init1_i)); // R7
  AST_ZERO_DELAY_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trip3_o) |-> $past(dly3_i) != '0); // R8
endmodule

bind bf_supervisor bf_supervisor_chk #(.N3(N3), .N1(N1), .TW(TW)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .init3_i  (init3_i),
  .init1_i  (init1_i),
  .ph_pu_i  (ph_pu_i),
  .nt_pu_i  (nt_pu_i),
  .dly3_i   (dly3_i),
  .trip3_o  (trip3_o),
  .trip1_o  (trip1_o),
  .retrip_o (retrip_o)
);

// File: tb/test_bf_supervisor.sv
module test_bf_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [2:0]  init3 = '0;
  logic [1:0]  init1 = '0;
  logic        ph = 1'b0, nt = 1'b0;
  logic [15:0] dly3 = 16'd5, dly1 = 16'd7, win = 16'd20;
  logic        trip3, trip1, retrip;

  int n_chk = 0, n_fail = 0, cyc = 0, tdiv = 0;

  // behavioural reference state
  int m_st = 0, m_wc = 0, m_c3 = 0, m_c1 = 0;
  bit m_l3 = 0, m_l1 = 0, m_t3 = 0, m_t1 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bf_supervisor i_bf_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .init3_i(init3), .init1_i(init1),
    .ph_pu_i(ph), .nt_pu_i(nt), .dly3_i(dly3), .dly1_i(dly1), .win_lim_i(win),
    .trip3_o(trip3), .trip1_o(trip1), .retrip_o(retrip)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % TICK_DIV;
    tick <= (tdiv == 0);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_wc = 0; m_c3 = 0; m_c1 = 0;
      m_l3 = 0; m_l1 = 0; m_t3 = 0; m_t1 = 0;
    end else begin
      bit a3, a1, any, clr, strt, run, arm3, arm1;
      int nst, nwc;
      a3 = |init3; a1 = |init1; any = a3 | a1;
      run  = (m_st == 1);
      clr  = (m_st == 0) || (m_st == 2 && !any);
      strt = (m_st == 0) && any && (win != 0);
      arm3 = run && dly3 != 0 && m_c3 >= int'(dly3) && a3 && (ph || nt);
      arm1 = run && dly1 != 0 && m_c1 >= int'(dly1) && a1 && ph;
      nst = m_st; nwc = m_wc;
      if (m_st == 0 && strt) begin nst = 1; nwc = 0; end
      else if (m_st == 1 && tick) begin
        if (m_wc + 1 >= int'(win)) nst = 2; else nwc = m_wc + 1;
      end else if (m_st == 2 && !any) nst = 0;
      if (clr) begin m_c3 = 0; m_c1 = 0; end
      else begin
        if (run && m_l3 && tick && m_c3 < int'(dly3)) m_c3++;
        if (run && m_l1 && tick && m_c1 < int'(dly1)) m_c1++;
      end
      m_l3 = (clr ? 1'b0 : m_l3) | (a3 && (strt || run));
      m_l1 = (clr ? 1'b0 : m_l1) | (a1 && (strt || run));
      m_t3 = clr ? 1'b0 : (m_t3 | arm3);
      m_t1 = clr ? 1'b0 : (m_t1 | arm1);
      m_st = nst; m_wc = nwc;
    end
  end

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    cyc++;
    check("R2 model trip3", int'(trip3), int'(m_t3));
    check("R6 model trip1", int'(trip1), int'(m_t1));
    check("R1 model retrip", int'(retrip), int'(m_st == 1));
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      finish_run();
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_all(input int n);
    init3 = '0; init1 = '0; ph = 0; nt = 0;
    wait_cyc(n);
  endtask

  initial begin
    wait_cyc(3);
    check("R10 reset trip3", int'(trip3), 0);
    check("R10 reset retrip", int'(retrip), 0);
    rst_n = 1;
    wait_cyc(2);

    // three-pole with phase pickup
    init3 = 3'b001; ph = 1;
    wait_cyc(2);
    check("R1 retrip on", int'(retrip), 1);
    wait_cyc(38);
    check("R2 trip3 set", int'(trip3), 1);
    check("R7 trip1 quiet", int'(trip1), 0);
    idle_all(100);
    check("R9 cleared trip3", int'(trip3), 0);
    check("R9 window closed", int'(retrip), 0);

    // brief initiate, then back at timeout: latched timing
    init3 = 3'b010; ph = 1;
    wait_cyc(3);
    init3 = '0;
    wait_cyc(22);
    init3 = 3'b010;
    wait_cyc(5);
    check("R3 latched delay trip3", int'(trip3), 1);
    idle_all(100);

    // single-pole with neutral only, then phase
    init1 = 2'b01; nt = 1;
    wait_cyc(60);
    check("R7 neutral only trip1", int'(trip1), 0);
    ph = 1;
    wait_cyc(5);
    check("R6 phase trip1", int'(trip1), 1);
    check("R6 trip3 untouched", int'(trip3), 0);
    idle_all(100);

    // pickup only after window expiry
    init3 = 3'b100;
    wait_cyc(95);
    check("R9 no reopen while held", int'(retrip), 0);
    ph = 1;
    wait_cyc(10);
    check("R4 no trip after window", int'(trip3), 0);
    idle_all(10);

    // latch-in after pickup and initiate drop
    init3 = 3'b001; nt = 1;
    wait_cyc(40);
    check("R2 neutral trip3", int'(trip3), 1);
    nt = 0;
    wait_cyc(10);
    init3 = '0;
    wait_cyc(10);
    check("R5 held trip3", int'(trip3), 1);
    idle_all(100);
    check("R9 released trip3", int'(trip3), 0);

    // zero delay disables path
    dly3 = 0;
    init3 = 3'b001; ph = 1;
    wait_cyc(60);
    check("R8 zero delay trip3", int'(trip3), 0);
    check("R8 zero delay retrip", int'(retrip), 1);
    idle_all(100);
    dly3 = 5;
    win = 0;
    init3 = 3'b001; init1 = 2'b10; ph = 1;
    wait_cyc(30);
    check("R8 zero window retrip", int'(retrip), 0);
    idle_all(5);
    win = 20;

    // reset during a trip
    init3 = 3'b001; ph = 1;
    wait_cyc(40);
    check("R2 trip before reset", int'(trip3), 1);
    #1 rst_n = 0;
    #1;
    check("R10 async reset trip3", int'(trip3), 0);
    check("R10 async reset retrip", int'(retrip), 0);
    idle_all(3);
    rst_n = 1;
    wait_cyc(5);
    finish_run();
  end
endmodule